// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetch Engine

This block follows a chain of DMA descriptors kept in memory and turns each one into a transfer command for a separate data mover. Each descriptor is 32 bytes, or eight 32-bit words. The engine reads descriptors through a request/response memory port. One request can cover a whole group of descriptors that sit next to each other in memory. A count field in the descriptor sets the size of the next group, and the group is always cut short at a 4 KB page boundary.

Every descriptor that arrives is checked for a validation code and for fetch errors. A good descriptor is decoded into source, destination, byte length and end-of-packet, and offered to the data mover on a valid/ready channel. Software supplies three things on configuration inputs: the first descriptor address (as two 32-bit halves), the size of the first group, and a global enable for completion events. A rising edge on the run input starts a walk.

The engine reports the following while it walks:
- a busy flag;
- sticky flags for a stop-bit halt, a bad validation code and a fetch error;
- a one-cycle completion event;
- a count of descriptors the data mover has accepted.

Top module: `sgdesc_walker`

## Requirements
- R1: Descriptor word layout, counting words from the descriptor's base address:
  - word 1 bits 27:0 are the byte length (bits 31:28 are ignored);
  - words 2/3 are the source address (low/high);
  - words 4/5 are the destination address (low/high);
  - word 0 bit 4 is end-of-packet.

  These fields appear on the transfer outputs exactly as stored.
- R2: If word 0 bits 31:16 differ from 0xAD4B, that descriptor is not offered. The magic-stopped flag is set, no further request is issued, and busy clears once the outstanding words of the current request have been received.
- R3: Each read request asks for 1 + N consecutive descriptors. For the first request, N is the first-group input. After that, N is word 0 bits 13:8 of the last descriptor of the previous request. The next request address is that descriptor's words 6/7 (low/high).
- R4: The request count is clipped so that address + 32 × count does not pass the next 4 KB boundary, with a minimum of one descriptor.
- R5: Once the data mover accepts a descriptor with word 0 bit 0 set, the engine stops. It sets the descriptor-stopped flag and issues no further request, and busy clears after any outstanding words of the request have been drained.
- R6: The completion event pulses for one cycle after the data mover accepts a descriptor with word 0 bit 1 set, but only if the global completion enable is high at that moment.
- R7: A 0-to-1 change on run while the engine is idle starts a walk. Busy is high from the next cycle, and all status flags are cleared at that point. While busy is low, no request and no transfer is offered.
- R8: If run is low when the data mover accepts a descriptor, that descriptor is the last one offered. Busy then clears with no status flag set.
- R9: The 32-bit done counter goes up by one for each descriptor the data mover accepts. It is cleared when a walk starts.
- R10: If a response word of a descriptor carries the error flag, that descriptor is not offered and the descriptor-error flag is set. This check takes priority over the magic check. The engine then stops as in R2.
- R11: While a transfer is offered and not yet accepted, the valid signal and all transfer fields hold steady.
- R12: After reset, busy, all flags, the done counter, the request valid and the transfer valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run control; rising edge starts, low stops after current descriptor |
| first_addr_lo | input | 32 | First descriptor address, low half |
| first_addr_hi | input | 32 | First descriptor address, high half |
| first_adj | input | 6 | Extra descriptors in the first request |
| ie_desc_done | input | 1 | Global completion-event enable |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Byte address of the first descriptor in the request |
| rd_req_count | output | 7 | Number of descriptors requested (1..64) |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_ready | output | 1 | Engine accepts a response word |
| rd_rsp_data | input | 32 | Response word, in address order |
| rd_rsp_err | input | 1 | Response word carries a fetch error |
| xfer_valid | output | 1 | Decoded transfer offered |
| xfer_ready | input | 1 | Data mover accepts the transfer |
| xfer_src | output | 64 | Source address |
| xfer_dst | output | 64 | Destination address |
| xfer_len | output | 28 | Byte length |
| xfer_eop | output | 1 | End of packet |
| busy | output | 1 | Walk in progress |
| st_desc_stopped | output | 1 | Halted on a stop bit |
| st_magic_stopped | output | 1 | Halted on a bad validation code |
| st_desc_error | output | 1 | Halted on a fetch error |
| cmp_event | output | 1 | One-cycle completion event |
| done_count | output | 32 | Descriptors accepted since start |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- **Next-pointer source.** The bench places decoy next-pointer and group-count values in descriptors that are not last in their group. An engine that follows the wrong descriptor requests from the wrong address.
- **Page clipping.** A walk starts 128 bytes below a page edge with a group of eight. Clipping off by one would show as a request for five descriptors instead of four, or as a second request that is never clipped.
- **Fault ordering.** Bad-magic and fetch-error descriptors are placed mid-group. A design that misorders the two checks, or that goes idle before the remaining words of the request drain, leaves words unconsumed or sets the wrong flag.
- **Run clear and event gating.** A run clear lands exactly on an acceptance, and the completion enable is toggled. An engine that samples run one cycle late, or ignores the enable, shows an extra transfer or extra events.

// File: rtl/sgdesc_pkg.sv
package sgdesc_pkg;
  localparam int DESC_WORDS = 8;
  localparam int DESC_BYTES = 32;
  localparam int ADJ_W      = 6;
  localparam int LEN_W      = 28;
  localparam logic [15:0] DESC_MAGIC = 16'hAD4B;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RECV,
    S_CHECK,
    S_OUT,
    S_DRAIN
  } walk_state_e;
endpackage

// File: rtl/sgdesc_burst.sv
// Group size for one read request: 1 + adj, cut at the page edge, at least one.
module sgdesc_burst
  import sgdesc_pkg::*;
#(
  parameter int PAGE_BYTES = 4096,
  localparam int PG_W = $clog2(PAGE_BYTES),
  localparam int BC_W = ADJ_W + 1
) (
  input  logic [PG_W-1:0]  offs,
  input  logic [ADJ_W-1:0] adj,
  output logic [BC_W-1:0]  count
);
  logic [31:0]     room;
  logic [BC_W-1:0] want;

  always_comb begin
    room = (32'(PAGE_BYTES) - {{(32-PG_W){1'b0}}, offs}) >> $clog2(DESC_BYTES);
    want = {1'b0, adj} + 1'b1;
    if ({{(32-BC_W){1'b0}}, want} <= room) count = want;
    else if (room == 32'd0)                count = BC_W'(1);
    else                                    count = room[BC_W-1:0];
  end
endmodule

// File: rtl/sgdesc_collect.sv
// Holds the eight words of the descriptor being received and decodes its fields.
module sgdesc_collect
  import sgdesc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             wr_err,
  output logic             magic_ok,
  output logic [ADJ_W-1:0] adj,
  output logic             f_stop,
  output logic             f_irq,
  output logic             f_eop,
  output logic [LEN_W-1:0] len,
  output logic [63:0]      src,
  output logic [63:0]      dst,
  output logic [63:0]      nxt,
  output logic             err_seen
);
  logic [31:0] words [DESC_WORDS];
  logic        unused_bits;

  // plain write-only storage, no reset, so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  // error seen on any word of this descriptor; restarts at word 0
  always_ff @(posedge clk) begin
    if (rst)        err_seen <= 1'b0;
    else if (wr_en) err_seen <= (wr_idx == 3'd0) ? wr_err : (err_seen | wr_err);
  end

  assign magic_ok = (words[0][31:16] == DESC_MAGIC);
  assign adj      = words[0][13:8];
  assign f_eop    = words[0][4];
  assign f_irq    = words[0][1];
  assign f_stop   = words[0][0];
  assign len      = words[1][LEN_W-1:0];
  assign src      = {words[3], words[2]};
  assign dst      = {words[5], words[4]};
  assign nxt      = {words[7], words[6]};

  assign unused_bits = ^{words[0][15:14], words[0][7:5], words[0][3:2], words[1][31:LEN_W]};
endmodule

// File: rtl/sgdesc_walker.sv
module sgdesc_walker
  import sgdesc_pkg::*;
#(
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [31:0]      first_addr_lo,
  input  logic [31:0]      first_addr_hi,
  input  logic [ADJ_W-1:0] first_adj,
  input  logic             ie_desc_done,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [63:0]      rd_req_addr,
  output logic [ADJ_W:0]   rd_req_count,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [31:0]      rd_rsp_data,
  input  logic             rd_rsp_err,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [63:0]      xfer_src,
  output logic [63:0]      xfer_dst,
  output logic [LEN_W-1:0] xfer_len,
  output logic             xfer_eop,
  output logic             busy,
  output logic             st_desc_stopped,
  output logic             st_magic_stopped,
  output logic             st_desc_error,
  output logic             cmp_event,
  output logic [CNT_W-1:0] done_count
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int BC_W = ADJ_W + 1;
  localparam int WL_W = BC_W + $clog2(DESC_WORDS);

  walk_state_e      state;
  logic             run_q;
  logic [2:0]       widx;
  logic [WL_W-1:0]  words_left;
  logic             rsp_fire;

  logic             d_magic_ok, d_stop, d_irq, d_eop, d_err;
  logic [ADJ_W-1:0] d_adj;
  logic [LEN_W-1:0] d_len;
  logic [63:0]      d_src, d_dst, d_nxt;

  logic [63:0]      calc_addr;
  logic [ADJ_W-1:0] calc_adj;
  logic [BC_W-1:0]  calc_cnt;

  assign rd_rsp_ready = (state == S_RECV) || (state == S_DRAIN);
  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;

  sgdesc_collect u_collect (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rsp_fire && (state == S_RECV)),
    .wr_idx   (widx),
    .wr_data  (rd_rsp_data),
    .wr_err   (rd_rsp_err),
    .magic_ok (d_magic_ok),
    .adj      (d_adj),
    .f_stop   (d_stop),
    .f_irq    (d_irq),
    .f_eop    (d_eop),
    .len      (d_len),
    .src      (d_src),
    .dst      (d_dst),
    .nxt      (d_nxt),
    .err_seen (d_err)
  );

  // one clipper shared by the first request and every follow-on request
  always_comb begin
    if (state == S_IDLE) begin
      calc_addr = {first_addr_hi, first_addr_lo};
      calc_adj  = first_adj;
    end else begin
      calc_addr = d_nxt;
      calc_adj  = d_adj;
    end
  end

  sgdesc_burst #(.PAGE_BYTES(PAGE_BYTES)) u_burst (
    .offs  (calc_addr[PG_W-1:0]),
    .adj   (calc_adj),
    .count (calc_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= S_IDLE;
      run_q            <= 1'b0;
      widx             <= '0;
      words_left       <= '0;
      rd_req_valid     <= 1'b0;
      rd_req_addr      <= '0;
      rd_req_count     <= '0;
      xfer_valid       <= 1'b0;
      xfer_src         <= '0;
      xfer_dst         <= '0;
      xfer_len         <= '0;
      xfer_eop         <= 1'b0;
      busy             <= 1'b0;
      st_desc_stopped  <= 1'b0;
      st_magic_stopped <= 1'b0;
      st_desc_error    <= 1'b0;
      cmp_event        <= 1'b0;
      done_count       <= '0;
    end else begin
      run_q     <= run;
      cmp_event <= 1'b0;
      if (rsp_fire) words_left <= words_left - 1'b1;

      case (state)
        S_IDLE: begin
          if (run && !run_q) begin
            busy             <= 1'b1;
            st_desc_stopped  <= 1'b0;
            st_magic_stopped <= 1'b0;
            st_desc_error    <= 1'b0;
            done_count       <= '0;
            rd_req_valid     <= 1'b1;
            rd_req_addr      <= calc_addr;
            rd_req_count     <= calc_cnt;
            state            <= S_REQ;
          end
        end
        S_REQ: begin
          if (rd_req_ready) begin
            rd_req_valid <= 1'b0;
            words_left   <= {rd_req_count, 3'b000};
            widx         <= '0;
            state        <= S_RECV;
          end
        end
        S_RECV: begin
          if (rsp_fire) begin
            widx <= widx + 3'd1;
            if (widx == 3'd7) state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (d_err) begin
            st_desc_error <= 1'b1;
            state         <= S_DRAIN;
          end else if (!d_magic_ok) begin
            st_magic_stopped <= 1'b1;
            state            <= S_DRAIN;
          end else begin
            xfer_valid <= 1'b1;
            xfer_src   <= d_src;
            xfer_dst   <= d_dst;
            xfer_len   <= d_len;
            xfer_eop   <= d_eop;
            state      <= S_OUT;
          end
        end
        S_OUT: begin
          if (xfer_ready) begin
            xfer_valid <= 1'b0;
            done_count <= done_count + 1'b1;
            cmp_event  <= d_irq && ie_desc_done;
            if (d_stop) begin
              st_desc_stopped <= 1'b1;
              state           <= S_DRAIN;
            end else if (!run) begin
              state <= S_DRAIN;
            end else if (words_left != '0) begin
              widx  <= '0;
              state <= S_RECV;
            end else begin
              rd_req_valid <= 1'b1;
              rd_req_addr  <= calc_addr;
              rd_req_count <= calc_cnt;
              state        <= S_REQ;
            end
          end
        end
        S_DRAIN: begin
          if (words_left == '0 || (words_left == WL_W'(1) && rsp_fire)) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a request always asks for between one and 64 descriptors
  p_burst_bounds_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_count != '0) && (int'(rd_req_count) <= (1 << ADJ_W)));

  // R4: an aligned request never runs past the page edge
  p_page_clip_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && rd_req_addr[4:0] == 5'd0) |->
      (int'(rd_req_addr[PG_W-1:0]) + int'(rd_req_count) * DESC_BYTES) <= PAGE_BYTES);

  // R11: an offered transfer holds until accepted
  p_xfer_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> xfer_valid && $stable(xfer_src) && $stable(xfer_dst)
      && $stable(xfer_len) && $stable(xfer_eop));

  // R9: one count per acceptance
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=> done_count == $past(done_count) + 1'b1);

  // R6: an event follows an acceptance made with the enable high
  p_event_gate_r6: assert property (@(posedge clk) disable iff (rst)
    cmp_event |-> $past(ie_desc_done && xfer_valid && xfer_ready));

  // R2 / R10: after a fault nothing more is offered or requested
  p_fault_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st_magic_stopped || st_desc_error) |-> !xfer_valid && !rd_req_valid);

  // R7: an idle engine offers nothing
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xfer_valid && !rd_req_valid);
endmodule

// File: tb/test_sgdesc_walker.sv
module test_sgdesc_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [31:0] first_addr_lo = '0, first_addr_hi = '0;
  logic [5:0]  first_adj = '0;
  logic        ie_desc_done = 1'b0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [63:0] rd_req_addr;
  logic [6:0]  rd_req_count;
  logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [63:0] xfer_src, xfer_dst;
  logic [27:0] xfer_len;
  logic        xfer_eop, busy, st_desc_stopped, st_magic_stopped, st_desc_error, cmp_event;
  logic [31:0] done_count;

  sgdesc_walker i_sgdesc_walker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit [31:0] mem [longint];
  bit [31:0] q[$];
  longint eq_addr[$]; int eq_cnt[$];
  longint ex_src[$], ex_dst[$]; int ex_len[$]; bit ex_eop[$];
  int exp_n, exp_ev; bit exp_stop, exp_magic, exp_err;
  int cyc = 0, rsp_idx = 0, seen_x = 0, seen_ev = 0, err_word = -1, stop_after = 0, xr_mod = 1;
  bit mon_on = 0;
  bit f_req, f_rsp, f_xfer;
  longint r_addr, r_src, r_dst; int r_cnt, r_len; bit r_eop;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] rd(input longint a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  task automatic put_desc(input longint a, input bit [15:0] mg, input int adj, input bit stp,
                          input bit irq, input bit eop, input int len, input longint src,
                          input longint dst, input longint nxt);
    mem[a >> 2]       = {mg, 2'b00, adj[5:0], 3'b000, eop, 2'b00, irq, stp};
    mem[(a >> 2) + 1] = {4'hA, len[27:0]};
    mem[(a >> 2) + 2] = src[31:0];
    mem[(a >> 2) + 3] = src[63:32];
    mem[(a >> 2) + 4] = dst[31:0];
    mem[(a >> 2) + 5] = dst[63:32];
    mem[(a >> 2) + 6] = nxt[31:0];
    mem[(a >> 2) + 7] = nxt[63:32];
  endtask

  // behavioural walk of the list following the requirements
  task automatic build_expect(input longint start, input int adj0, input bit ie);
    longint addr = start; int adj = adj0; int wc = 0; bit done = 0; int guard = 0;
    exp_n = 0; exp_ev = 0; exp_stop = 0; exp_magic = 0; exp_err = 0;
    while (!done && guard < 200) begin
      int room = (4096 - int'(addr % 4096)) / 32;
      int n = adj + 1;
      guard++;
      if (n > room) n = room;
      if (n < 1) n = 1;
      eq_addr.push_back(addr); eq_cnt.push_back(n);
      for (int i = 0; i < n; i++) begin
        longint d = addr + 32 * i;
        bit [31:0] w0 = rd(d);
        if (err_word >= wc && err_word < wc + 8) begin exp_err = 1; done = 1; break; end
        wc += 8;
        if (w0[31:16] != 16'hAD4B) begin exp_magic = 1; done = 1; break; end
        ex_src.push_back({rd(d + 12), rd(d + 8)});
        ex_dst.push_back({rd(d + 20), rd(d + 16)});
        ex_len.push_back(int'(rd(d + 4) & 32'h0FFF_FFFF));
        ex_eop.push_back(w0[4]);
        exp_n++;
        if (w0[1] && ie) exp_ev++;
        if (w0[0]) begin exp_stop = 1; done = 1; break; end
        if (exp_n == stop_after) begin done = 1; break; end
        if (i == n - 1) begin
          addr = {rd(d + 28), rd(d + 24)};
          adj = int'(w0[13:8]);
        end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (f_req) begin
      if (eq_addr.size() == 0) check(0, "R3 unexpected request", r_addr, 0);
      else begin
        longint ea = eq_addr.pop_front();
        int ec = eq_cnt.pop_front();
        check(r_addr == ea, "R3 request address", r_addr, ea);
        check(r_cnt == ec, "R4 request count", r_cnt, ec);
      end
      for (int k = 0; k < r_cnt * 8; k++) q.push_back(rd(r_addr + 4 * k));
    end
    if (f_rsp && q.size() > 0) begin void'(q.pop_front()); rsp_idx++; end
    if (f_xfer) begin
      if (ex_src.size() == 0) check(0, "R1 unexpected transfer", r_src, 0);
      else begin
        longint es = ex_src.pop_front(), ed = ex_dst.pop_front();
        int el = ex_len.pop_front(); bit ee = ex_eop.pop_front();
        check(r_src == es, "R1 source", r_src, es);
        check(r_dst == ed, "R1 destination", r_dst, ed);
        check(r_len == el, "R1 length", r_len, el);
        check(r_eop == ee, "R1 eop", r_eop, ee);
      end
      seen_x++;
    end
    if (cmp_event) seen_ev++;
    if (mon_on) check(done_count == 32'(seen_x), "R9 running count", done_count, seen_x);
    rd_rsp_valid = (q.size() > 0) && (cyc % 4 != 2);
    rd_rsp_data  = (q.size() > 0) ? q[0] : 32'h0;
    rd_rsp_err   = rd_rsp_valid && (rsp_idx == err_word);
    rd_req_ready = (cyc % 3) != 0;
    xfer_ready   = (cyc % xr_mod) != 1;
    #1;
    f_req  = rd_req_valid && rd_req_ready;
    r_addr = rd_req_addr; r_cnt = int'(rd_req_count);
    f_rsp  = rd_rsp_valid && rd_rsp_ready;
    f_xfer = xfer_valid && xfer_ready;
    r_src = xfer_src; r_dst = xfer_dst; r_len = int'(xfer_len); r_eop = xfer_eop;
    if (f_xfer && stop_after > 0 && seen_x + 1 == stop_after) run = 1'b0; // R8
  endtask

  task automatic run_case(input string name, input longint start, input int adj0, input bit ie,
                          input int errw, input int stopn, input int xr);
    int n = 0;
    eq_addr.delete(); eq_cnt.delete(); ex_src.delete(); ex_dst.delete();
    ex_len.delete(); ex_eop.delete(); q.delete();
    rsp_idx = 0; seen_x = 0; seen_ev = 0; err_word = errw; stop_after = stopn; xr_mod = xr;
    build_expect(start, adj0, ie);
    first_addr_lo = start[31:0]; first_addr_hi = start[63:32];
    first_adj = adj0[5:0]; ie_desc_done = ie;
    run = 1'b1;
    step();
    check(busy == 1'b1, {"R7 busy after start ", name}, busy, 1);
    check(done_count == 0, {"R9 count cleared ", name}, done_count, 0);
    check({st_desc_stopped, st_magic_stopped, st_desc_error} == 3'b000, {"R7 flags cleared ", name},
          {st_desc_stopped, st_magic_stopped, st_desc_error}, 0);
    mon_on = 1;
    while ((busy || q.size() != 0) && n < 20000) begin step(); n++; end
    if (n >= 20000) check(0, {"watchdog ", name}, n, 0);
    check(eq_addr.size() == 0, {"R3 requests missing ", name}, eq_addr.size(), 0);
    check(ex_src.size() == 0, {"R1 transfers missing ", name}, ex_src.size(), 0);
    check(done_count == 32'(exp_n), {"R9 final count ", name}, done_count, exp_n);
    check(seen_ev == exp_ev, {"R6 events ", name}, seen_ev, exp_ev);
    check(st_desc_stopped == exp_stop, {"R5 stopped flag ", name}, st_desc_stopped, exp_stop);
    check(st_magic_stopped == exp_magic, {"R2 magic flag ", name}, st_magic_stopped, exp_magic);
    check(st_desc_error == exp_err, {"R10 error flag ", name}, st_desc_error, exp_err);
    mon_on = 0;
    run = 1'b0;
    step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // single-descriptor links with an irrelevant adj only on non-last entries
    put_desc(64'h10000, 16'hAD4B, 0, 0, 0, 1, 28'h0000100, 64'h1111_0000_0000_0010, 64'h2222_0000_0000_0020, 64'h20040);
    put_desc(64'h20040, 16'hAD4B, 0, 0, 1, 0, 28'hFFFFFFF, 64'h3, 64'h4, 64'h10100);
    put_desc(64'h10100, 16'hAD4B, 0, 1, 1, 1, 28'h0000040, 64'h5, 64'h6, 64'hDEAD0000);
    // group of four then group of three; decoys in non-last entries
    for (int i = 0; i < 4; i++)
      put_desc(64'h31000 + 32 * i, 16'hAD4B, (i == 3) ? 2 : 9, 0, i[0], i[1], 100 + i,
               64'hA000 + i, 64'hB000 + i, (i == 3) ? 64'h33000 : 64'h99990000);
    for (int i = 0; i < 3; i++)
      put_desc(64'h33000 + 32 * i, 16'hAD4B, 7, (i == 2), 1, 0, 200 + i,
               64'hC000 + i, 64'hD000 + i, 64'h88880000);
    // page clip: four fit, then two fit
    for (int i = 0; i < 4; i++)
      put_desc(64'h42F80 + 32 * i, 16'hAD4B, 5, 0, 0, 0, 300 + i,
               64'hE000 + i, 64'hF000 + i, 64'h44FC0);
    put_desc(64'h44FC0, 16'hAD4B, 0, 0, 1, 0, 400, 64'h1, 64'h2, 64'h0);
    put_desc(64'h44FE0, 16'hAD4B, 0, 1, 1, 1, 401, 64'h3, 64'h4, 64'h0);
    // bad magic in the middle of a group of two
    put_desc(64'h50000, 16'hAD4B, 1, 0, 0, 0, 500, 64'h50, 64'h51, 64'h50020);
    put_desc(64'h50020, 16'h1234, 0, 0, 0, 0, 501, 64'h52, 64'h53, 64'h0);
    put_desc(64'h50040, 16'hAD4B, 0, 1, 0, 0, 502, 64'h54, 64'h55, 64'h0);
    // endless ring of five for the run-clear case
    for (int i = 0; i < 5; i++)
      put_desc(64'h60000 + 32 * i, 16'hAD4B, 4, 0, 0, 0, 600 + i, 64'h600 + i, 64'h700 + i, 64'h60000);

    f_req = 0; f_rsp = 0; f_xfer = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R12 reset state
    check(busy == 0, "R12 busy", busy, 0);
    check(rd_req_valid == 0 && xfer_valid == 0, "R12 valids", {rd_req_valid, xfer_valid}, 0);
    check(done_count == 0, "R12 count", done_count, 0);
    check({st_desc_stopped, st_magic_stopped, st_desc_error, cmp_event} == 4'b0, "R12 flags",
          {st_desc_stopped, st_magic_stopped, st_desc_error, cmp_event}, 0);

    run_case("chain",  64'h10000, 0, 1, -1, 0, 1);   // R1 R5 R6 R9
    run_case("groups", 64'h31000, 3, 1, -1, 0, 3);   // R3 R11
    run_case("clip",   64'h42F80, 7, 1, -1, 0, 1);   // R4
    run_case("ie_off", 64'h10000, 0, 0, -1, 0, 2);   // R6
    run_case("magic",  64'h50000, 0, 1, -1, 0, 1);   // R2
    run_case("ferr",   64'h31000, 3, 1, 11, 0, 1);   // R10
    run_case("runclr", 64'h60000, 4, 1, -1, 2, 1);   // R8
    run_case("again",  64'h10000, 0, 1, -1, 0, 3);   // R9 restart clears

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule